// File: doc/BRIEF.md
# Programmable-Modulus Loop-Filter Counter

This block is the loop filter of an all-digital phase-locked loop. It runs on the loop-filter clock, which is a fixed multiple of the loop centre frequency. On each rising edge it steps an internal count up or down, as the direction input says. The direction input is normally the phase-detector output. An enable input gates the stepping.

A 4-bit code picks the counter modulus, a power of two between 8 and 131072. Code zero switches the counter off. The code may be changed while the loop runs, which retunes the loop bandwidth on the fly. When the count wraps past its top going up, the block emits a one-cycle carry pulse. When it wraps below zero going down, it emits a one-cycle borrow pulse. A downstream pulse add/delete stage consumes these pulses.

Top module: `loop_filter_counter`

## Requirements
- R1: With modCode = 0 the counter is inhibited: no carry or borrow is produced and the count is held, so stepping resumes from the same value when a non-zero code returns.
- R2: modCode = n (1..15) sets the modulus to 2^(n+2); a steady run of up steps gives exactly one carry per 2^(n+2) steps.
- R3: An up step from modulus-1 wraps the count to 0 and raises carry for exactly the one clock cycle after that rising edge.
- R4: A down step from 0 wraps the count to modulus-1 and raises borrow for exactly the one clock cycle after that rising edge.
- R5: dirDown is sampled at the rising clock edge: 1 steps down, 0 steps up.
- R6: With countEn = 0 the count is held and no carry or borrow is produced.
- R7: After a modCode change, the count is taken modulo the new modulus (upper bits masked off), so the next wrap happens at the new modulus.
- R8: Active-low rstN clears the count and holds carry and borrow low.
- R9: carry and borrow are never high in the same cycle, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop-filter clock (M times centre frequency) |
| rstN | input | 1 | Asynchronous active-low reset |
| dirDown | input | 1 | Step direction, 1 = down, 0 = up |
| countEn | input | 1 | Step enable |
| modCode | input | 4 | Modulus select, 0 = off, n = 2^(n+2) |
| carry | output | 1 | One-cycle pulse on an upward wrap |
| borrow | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The count register is never visible directly. Any error in it shows up at the ports as a carry or borrow in the wrong cycle, so the bench records the exact step on which the first pulse appears. A corrupted count, a wrong mask after a code change, or a count that moved while inhibited or disabled all shift that first pulse by at least one cycle. The shift appears within one modulus of stepping. A wrong modulus decode changes the number of pulses counted over a fixed run.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  // Strobes from the control decode to the count datapath
  typedef struct packed {
    logic step;   // advance the count this edge
    logic down;   // direction of the advance
  } lfcStrobe_t;
endpackage

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int COUNT_W = 17,
  parameter int LOG_OFS = 2
) (
  input  logic               dirDown,
  input  logic               countEn,
  input  logic [CODE_W-1:0]  modCode,
  output lfcStrobe_t         strobe,
  output logic [COUNT_W-1:0] modMask
);
  localparam int MAX_LOG = (1 << CODE_W) - 1 + LOG_OFS;

  initial begin
    if (COUNT_W < MAX_LOG) $error("COUNT_W too small for the modulus code range");
  end

  logic codeOff;
  int   modLog;

  always_comb begin
    codeOff = (modCode == '0);
    modLog  = int'(modCode) + LOG_OFS;
  end

  // Mask of the live bits: bit i active when i < code + offset
  for (genvar gi = 0; gi < COUNT_W; gi++) begin : g_mask
    assign modMask[gi] = !codeOff && (gi < modLog);
  end

  always_comb begin
    strobe.step = countEn && !codeOff;
    strobe.down = dirDown;
  end
endmodule

// File: rtl/lfc_datapath.sv
module lfc_datapath
  import lfc_pkg::*;
#(
  parameter int COUNT_W = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  lfcStrobe_t         strobe,
  input  logic [COUNT_W-1:0] modMask,
  output logic               carry,
  output logic               borrow
);
  logic [COUNT_W-1:0] countQ, countD, liveCount;
  logic atTop, atZero, carryD, borrowD;

  always_comb begin
    liveCount = countQ & modMask;
    atTop     = (liveCount == modMask);
    atZero    = (liveCount == '0);
    countD    = countQ;
    carryD    = 1'b0;
    borrowD   = 1'b0;
    if (strobe.step) begin
      if (strobe.down) begin
        if (atZero) begin
          countD  = modMask;
          borrowD = 1'b1;
        end else begin
          countD  = liveCount - 1'b1;
        end
      end else begin
        if (atTop) begin
          countD = '0;
          carryD = 1'b1;
        end else begin
          countD = liveCount + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else begin
      countQ <= countD;
      carry  <= carryD;
      borrow <= borrowD;
    end
  end

  // R1 / R6: no step means the count holds and no pulse follows
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> ($stable(countQ) && !carry && !borrow));

  // R7: after a step the count lies inside the mask it was computed with
  p_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((countQ & ~$past(modMask)) == '0));

  // R3: a carry follows only an up step
  p_carry_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carry) |-> ($past(strobe.step) && !$past(strobe.down)));

  // R4: a borrow follows only a down step and leaves the count at the top
  p_borrow_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(borrow) |-> (countQ == $past(modMask)));
endmodule

// File: rtl/loop_filter_counter.sv
module loop_filter_counter
  import lfc_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int COUNT_W = 17,
  parameter int LOG_OFS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirDown,
  input  logic              countEn,
  input  logic [CODE_W-1:0] modCode,
  output logic              carry,
  output logic              borrow
);
  lfcStrobe_t         strobe;
  logic [COUNT_W-1:0] modMask;

  lfc_ctrl #(.CODE_W(CODE_W), .COUNT_W(COUNT_W), .LOG_OFS(LOG_OFS)) i_ctrl (
    .dirDown (dirDown),
    .countEn (countEn),
    .modCode (modCode),
    .strobe  (strobe),
    .modMask (modMask)
  );

  lfc_datapath #(.COUNT_W(COUNT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .modMask (modMask),
    .carry   (carry),
    .borrow  (borrow)
  );

  // R9: wrap pulses are exclusive and one cycle wide
  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(carry && borrow));
  p_carry_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    carry |=> !carry);
  p_borrow_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    borrow |=> !borrow);
  // R1: code zero gives no pulse on the next cycle
  p_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modCode == '0) |=> (!carry && !borrow));
endmodule

// File: tb/test_loop_filter_counter.sv
module test_loop_filter_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirDown = 1'b0;
  logic countEn = 1'b0;
  logic [3:0] modCode = 4'd0;
  logic carry, borrow;

  always #2.5 clk = ~clk;

  loop_filter_counter i_loop_filter_counter (
    .clk(clk), .rstN(rstN), .dirDown(dirDown), .countEn(countEn),
    .modCode(modCode), .carry(carry), .borrow(borrow)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int nCarry, nBorrow, firstCarry, firstBorrow;
  bit badPulse;

  typedef struct packed {
    logic [3:0]  code;
    logic        down;
    logic        en;
    int unsigned n;
    int unsigned expC;
    int unsigned expB;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  1'b0, 1'b1, 8,   1, 0},   // R2 R3 mod 8
    '{4'd1,  1'b0, 1'b1, 16,  2, 0},   // R2
    '{4'd1,  1'b1, 1'b1, 1,   0, 1},   // R4 R5
    '{4'd1,  1'b1, 1'b1, 9,   0, 2},   // R4
    '{4'd2,  1'b0, 1'b1, 16,  1, 0},   // R2 mod 16
    '{4'd2,  1'b0, 1'b1, 15,  0, 0},   // R2 just below
    '{4'd0,  1'b0, 1'b1, 20,  0, 0},   // R1
    '{4'd1,  1'b0, 1'b0, 20,  0, 0},   // R6
    '{4'd3,  1'b1, 1'b1, 33,  0, 2},   // R4 mod 32
    '{4'd6,  1'b0, 1'b1, 256, 1, 0},   // R2 mod 256
    '{4'd15, 1'b1, 1'b1, 1,   0, 1},   // R4 largest modulus
    '{4'd15, 1'b0, 1'b1, 100, 0, 0}    // R2 largest modulus
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!carry && !borrow, "R8 outputs low in reset", {carry, borrow}, 0);
    rstN = 1'b1;
  endtask

  // Runs n cycles from a negedge; step numbers count from 1
  task automatic run(input logic [3:0] code, input logic down, input logic en, input int n);
    bit lastC = 0;
    bit lastB = 0;
    nCarry = 0; nBorrow = 0; firstCarry = 0; firstBorrow = 0; badPulse = 0;
    modCode = code; dirDown = down; countEn = en;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (carry && borrow) badPulse = 1;
      if ((carry && lastC) || (borrow && lastB)) badPulse = 1;
      lastC = carry; lastB = borrow;
      if (carry) begin nCarry++; if (firstCarry == 0) firstCarry = k; end
      if (borrow) begin nBorrow++; if (firstBorrow == 0) firstBorrow = k; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // Vector walk, each vector from a cleared count
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      run(VECS[v].code, VECS[v].down, VECS[v].en, int'(VECS[v].n));
      check(nCarry == int'(VECS[v].expC), $sformatf("R2/R3 vec%0d carries", v), nCarry, int'(VECS[v].expC));
      check(nBorrow == int'(VECS[v].expB), $sformatf("R4/R5 vec%0d borrows", v), nBorrow, int'(VECS[v].expB));
      check(!badPulse, $sformatf("R9 vec%0d pulse shape", v), badPulse, 0);
    end

    // R3: first carry exactly on step 8 at modulus 8
    doReset();
    run(4'd1, 1'b0, 1'b1, 10);
    check(firstCarry == 8, "R3 carry step", firstCarry, 8);

    // R7: count 20 at mod 64, then mod 8 masks to 4, carry on 4th step
    doReset();
    run(4'd4, 1'b0, 1'b1, 20);
    run(4'd1, 1'b0, 1'b1, 6);
    check(firstCarry == 4, "R7 masked wrap", firstCarry, 4);

    // R5: up 3, down 3 back to 0 with no borrow, then one more down borrows
    doReset();
    run(4'd1, 1'b0, 1'b1, 3);
    run(4'd1, 1'b1, 1'b1, 3);
    check(nBorrow == 0, "R5 down to zero", nBorrow, 0);
    run(4'd1, 1'b1, 1'b1, 1);
    check(firstBorrow == 1, "R4 borrow from zero", firstBorrow, 1);

    // R1: count 5, inhibit 10 cycles, resume: carry on 3rd step
    doReset();
    run(4'd1, 1'b0, 1'b1, 5);
    run(4'd0, 1'b0, 1'b1, 10);
    check(nCarry == 0, "R1 no carry inhibited", nCarry, 0);
    run(4'd1, 1'b0, 1'b1, 4);
    check(firstCarry == 3, "R1 count held", firstCarry, 3);

    // R6: count 6, disabled 10 cycles, resume: carry on 2nd step
    doReset();
    run(4'd1, 1'b0, 1'b1, 6);
    run(4'd1, 1'b0, 1'b0, 10);
    run(4'd1, 1'b0, 1'b1, 3);
    check(firstCarry == 2, "R6 count held", firstCarry, 2);

    // R8: reset mid-run clears count, next carry on 8th step
    doReset();
    run(4'd1, 1'b0, 1'b1, 5);
    doReset();
    run(4'd1, 1'b0, 1'b1, 9);
    check(firstCarry == 8, "R8 count cleared", firstCarry, 8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule